// File: doc/BRIEF.md
# Structure De-interleaving Load/Store Unit

This unit sits between a memory data stream and a bank of four 64-bit vector registers. A memory run holds a packed sequence of records, and each record has one to four elements of equal width (8, 16 or 32 bits). On a load, the unit takes the run one 64-bit beat at a time. It places every element straight into its final slot, so destination register k collects element k of every record. Record 0 sits in the lowest lane of each register and later records fill higher lanes. No separate permute pass over the registers is needed afterwards. For example, with 16-bit elements and three elements per record, four records (twelve halfwords) arrive in three beats and fill three registers.

The element count and element size are captured when an operation starts. A register holds 64/w lanes, so an operation moves exactly `count` beats. When the last beat has been taken, the unit raises one write-enable for each used register and a one-cycle done pulse. The reverse direction takes a snapshot of four register values and emits them in memory order as `count` beats. Storing the registers that a load produced gives back the original memory run.

Top module: `struct_deinterleave`

## Requirements
- R1: After a synchronous active-low reset, reg_we is 0, done is 0, in_ready is 0, out_valid is 0 and reg_data is all zeros.
- R2: A load started by ld_start (count n = cfg_count_m1+1) raises in_ready in the cycle after the start edge and accepts exactly n beats; in_ready is low again once the n-th beat has been taken.
- R3: Memory is little-endian, so element e of the run sits in bits [(e mod L)*w +: w] of beat e/L, where L = 64/w. Element k of record r (run element r*n+k) lands in reg_data bits [k*64 + r*w +: w], which is register k, lane r.
- R4: cfg_size selects the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits; code 3 behaves as 32 bits.
- R5: In the cycle after the edge that takes the last load beat, done is 1 for exactly one cycle and reg_we (bit k = register k) has bits 0..n-1 set and the rest clear. reg_data already holds the result in that cycle and keeps it until the next operation.
- R6: A cycle in which in_valid is low while a load waits takes no beat and does not shift the placement of later beats.
- R7: A store started by st_start captures st_regs. From the cycle after the start edge it drives out_valid with n beats, where beat b carries run elements b*L..b*L+L-1 and run element r*n+k is register k lane r. out_data holds steady while out_ready is low, and storing a loaded image reproduces the loaded run.
- R8: ld_start, st_start and configuration changes are ignored while an operation is in progress.
- R9: When ld_start and st_start are both high in an idle cycle, the load is started and the store request is dropped.
- R10: done also pulses for one cycle after the last store beat is taken, with reg_we all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_count_m1 | input | 2 | Elements per record minus one, captured at start |
| cfg_size | input | 2 | Element width code, captured at start |
| ld_start | input | 1 | Begin a de-interleaving load |
| st_start | input | 1 | Begin an interleaving store |
| st_regs | input | 256 | Register image for a store, register k in bits [k*64 +: 64] |
| in_valid | input | 1 | Memory beat offered |
| in_ready | output | 1 | Unit accepts a memory beat |
| in_data | input | 64 | Memory beat, lowest address in the low bits |
| out_valid | output | 1 | Store beat offered |
| out_ready | input | 1 | Consumer accepts the store beat |
| out_data | output | 64 | Store beat in memory order |
| reg_data | output | 256 | Register image, register k in bits [k*64 +: 64] |
| reg_we | output | 4 | Per-register write enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start request is taken on a rising edge. in_ready or out_valid is visible in the very next cycle. Each beat moves on the edge where valid and ready are both high. done, reg_we and the finished reg_data appear one cycle after the edge that moved the final beat, and done is gone one cycle later. The bench drives inputs on falling edges and samples on the following falling edge, so every check falls exactly one register stage after the stimulus it tests. Stall cycles are inserted at chosen beats, and the checks confirm that the outputs stay put through those gaps.

// File: rtl/sdl_pkg.sv
// Shared constants, state type and the lane mapping for the structure
// de-interleaving unit. Assumes a 64-bit beat and at most four elements.
package sdl_pkg;
    localparam int BEAT_W     = 64;
    localparam int BEAT_BYTES = BEAT_W / 8;
    localparam int BB_SH      = $clog2(BEAT_BYTES);
    localparam int MAX_ELEMS  = 4;
    localparam int IMG_W      = MAX_ELEMS * BEAT_W;
    localparam int IMG_BYTES  = IMG_W / 8;
    localparam int BIDX_W     = $clog2(IMG_BYTES);
    localparam int CNT_W      = $clog2(MAX_ELEMS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } op_state_e;

    // Maps a byte offset in the memory run to its byte offset in the register image.
    function automatic logic [BIDX_W-1:0] reg_byte_of(
        input logic [BIDX_W-1:0] gb,
        input logic [CNT_W-1:0]  cnt_m1,
        input logic [1:0]        size_code
    );
        logic [1:0]        sh;
        logic [BIDX_W-1:0] e;
        logic [BIDX_W-1:0] m;
        logic [BIDX_W-1:0] r;
        logic [BIDX_W-1:0] k;
        logic [BIDX_W+3:0] prod;
        sh   = (size_code == 2'd0) ? 2'd0 : (size_code == 2'd1) ? 2'd1 : 2'd2;
        e    = gb >> sh;
        m    = gb & ((BIDX_W'(1) << sh) - BIDX_W'(1));
        prod = '0;
        case (cnt_m1)
            2'd0: begin r = e;      k = '0; end
            2'd1: begin r = e >> 1; k = e & BIDX_W'(1); end
            2'd3: begin r = e >> 2; k = e & BIDX_W'(3); end
            default: begin
                // divide by three through a reciprocal multiply, exact for e < 32
                prod = (BIDX_W+4)'(e) * (BIDX_W+4)'(11);
                r    = BIDX_W'(prod >> 5);
                k    = e - r * BIDX_W'(3);
            end
        endcase
        return (k << BB_SH) + (r << sh) + m;
    endfunction
endpackage

// File: rtl/sdl_ctrl.sv
// Operation sequencer: captures the configuration at start, counts beats,
// arbitrates load over store and produces the write enables and done pulse.
// Assumes start requests are only meaningful while idle.
module sdl_ctrl
    import sdl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_start,
    input  logic             st_start,
    input  logic [CNT_W-1:0] cfg_count_m1,
    input  logic [1:0]       cfg_size,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load_fire,
    output logic             store_accept,
    output logic [CNT_W-1:0] cnt_m1,
    output logic [1:0]       size_code,
    output logic [CNT_W-1:0] beat_idx,
    output logic [MAX_ELEMS-1:0] reg_we,
    output logic             done
);
    op_state_e state_q;
    logic      store_fire;
    logic      last_beat;

    // Handshake and arbitration decode.
    always_comb begin
        in_ready     = (state_q == ST_LOAD);
        out_valid    = (state_q == ST_STORE);
        load_fire    = in_ready && in_valid;
        store_fire   = out_valid && out_ready;
        last_beat    = (beat_idx == cnt_m1);
        store_accept = (state_q == ST_IDLE) && !ld_start && st_start;
    end

    // State, captured configuration, beat counter and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_m1    <= '0;
            size_code <= '0;
            beat_idx  <= '0;
            reg_we    <= '0;
            done      <= 1'b0;
        end else begin
            reg_we <= '0;
            done   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (ld_start || st_start) begin
                        state_q   <= ld_start ? ST_LOAD : ST_STORE;
                        cnt_m1    <= cfg_count_m1;
                        size_code <= cfg_size;
                        beat_idx  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (load_fire) begin
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            for (int i = 0; i < MAX_ELEMS; i++) begin
                                reg_we[i] <= (CNT_W'(i) <= cnt_m1);
                            end
                        end else begin
                            beat_idx <= beat_idx + CNT_W'(1);
                        end
                    end
                end
                ST_STORE: begin
                    if (store_fire) begin
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            beat_idx <= beat_idx + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdl_scatter.sv
// Load datapath: writes every byte of one memory beat into its register
// image slot, giving the next image. Purely combinational.
module sdl_scatter
    import sdl_pkg::*;
(
    input  logic [IMG_W-1:0]  img_in,
    input  logic [BEAT_W-1:0] beat,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [CNT_W-1:0]  cnt_m1,
    input  logic [1:0]        size_code,
    output logic [IMG_W-1:0]  img_out
);
    logic [BIDX_W-1:0] dest;

    // Place each beat byte at its mapped register byte.
    always_comb begin
        img_out = img_in;
        dest    = '0;
        for (int q = 0; q < BEAT_BYTES; q++) begin
            dest = reg_byte_of((BIDX_W'(beat_idx) << BB_SH) | BIDX_W'(q), cnt_m1, size_code);
            img_out[dest*8 +: 8] = beat[q*8 +: 8];
        end
    end
endmodule

// File: rtl/sdl_gather.sv
// Store datapath: builds one memory-order beat by pulling each byte from
// its register image slot. Purely combinational.
module sdl_gather
    import sdl_pkg::*;
(
    input  logic [IMG_W-1:0]  img,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [CNT_W-1:0]  cnt_m1,
    input  logic [1:0]        size_code,
    output logic [BEAT_W-1:0] beat
);
    for (genvar q = 0; q < BEAT_BYTES; q++) begin : g_byte
        logic [BIDX_W-1:0] src;
        // Source byte of beat byte q.
        always_comb begin
            src = reg_byte_of((BIDX_W'(beat_idx) << BB_SH) | BIDX_W'(q), cnt_m1, size_code);
        end
        assign beat[q*8 +: 8] = img[src*8 +: 8];
    end
endmodule

// File: rtl/struct_deinterleave.sv
// Top of the structure de-interleaving load/store unit. Holds the
// four-register image that loads fill and stores drain. Assumes the
// consumer latches reg_data while reg_we is high.
module struct_deinterleave
    import sdl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_count_m1,
    input  logic [1:0]           cfg_size,
    input  logic                 ld_start,
    input  logic                 st_start,
    input  logic [IMG_W-1:0]     st_regs,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [BEAT_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [BEAT_W-1:0]    out_data,
    output logic [IMG_W-1:0]     reg_data,
    output logic [MAX_ELEMS-1:0] reg_we,
    output logic                 done
);
    logic [IMG_W-1:0] img_q;
    logic [IMG_W-1:0] img_next;
    logic             load_fire;
    logic             store_accept;
    logic [CNT_W-1:0] cnt_m1;
    logic [1:0]       size_code;
    logic [CNT_W-1:0] beat_idx;

    sdl_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_start     (ld_start),
        .st_start     (st_start),
        .cfg_count_m1 (cfg_count_m1),
        .cfg_size     (cfg_size),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .load_fire    (load_fire),
        .store_accept (store_accept),
        .cnt_m1       (cnt_m1),
        .size_code    (size_code),
        .beat_idx     (beat_idx),
        .reg_we       (reg_we),
        .done         (done)
    );

    sdl_scatter u_scatter (
        .img_in    (img_q),
        .beat      (in_data),
        .beat_idx  (beat_idx),
        .cnt_m1    (cnt_m1),
        .size_code (size_code),
        .img_out   (img_next)
    );

    sdl_gather u_gather (
        .img       (img_q),
        .beat_idx  (beat_idx),
        .cnt_m1    (cnt_m1),
        .size_code (size_code),
        .beat      (out_data)
    );

    // Register image: snapshot on store start, updated per accepted load beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (store_accept) begin
            img_q <= st_regs;
        end else if (load_fire) begin
            img_q <= img_next;
        end
    end

    assign reg_data = img_q;
endmodule

// File: rtl/sdl_chk.sv
// Protocol checker for struct_deinterleave, attached by bind. Observes
// ports only; assumes the synchronous active-low reset.
module sdl_chk
    import sdl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [BEAT_W-1:0]    out_data,
    input logic [MAX_ELEMS-1:0] reg_we
    ,input logic                done
);
    assert_one_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_we_only_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we != '0) |-> done);

    assert_done_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_follows_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past((in_valid && in_ready) || (out_valid && out_ready)));

    assert_store_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_we_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});
endmodule

bind struct_deinterleave sdl_chk u_sdl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .reg_we    (reg_we),
    .done      (done)
);

// File: tb/tb_struct_deinterleave.sv
// Directed bench for struct_deinterleave: one task per scenario.
module tb_struct_deinterleave;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_count_m1 = '0;
    logic [1:0]   cfg_size = '0;
    logic         ld_start = 1'b0;
    logic         st_start = 1'b0;
    logic [255:0] st_regs = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [63:0]  out_data;
    logic [255:0] reg_data;
    logic [3:0]   reg_we;
    logic         done;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    struct_deinterleave dut (.*);

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int width_of(input int code);
        return (code == 0) ? 8 : (code == 1) ? 16 : 32;
    endfunction

    function automatic logic [255:0] make_mem(input int seed);
        logic [255:0] m;
        for (int i = 0; i < 32; i++) m[i*8 +: 8] = 8'(seed + i * 37 + (i >> 2));
        return m;
    endfunction

    function automatic logic [255:0] used_mask(input int n);
        logic [255:0] m = '0;
        for (int i = 0; i < n * 64; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Requirement model: run element r*n+k goes to register k lane r.
    function automatic logic [255:0] model_load(input logic [255:0] mem, input int n, input int w);
        logic [255:0] res = '0;
        for (int k = 0; k < n; k++)
            for (int r = 0; r < 64 / w; r++)
                for (int t = 0; t < w; t++)
                    res[k*64 + r*w + t] = mem[(r*n + k)*w + t];
        return res;
    endfunction

    function automatic logic [255:0] model_store(input logic [255:0] regs, input int n, input int w);
        logic [255:0] res = '0;
        for (int k = 0; k < n; k++)
            for (int r = 0; r < 64 / w; r++)
                for (int t = 0; t < w; t++)
                    res[(r*n + k)*w + t] = regs[k*64 + r*w + t];
        return res;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_we == 4'd0 && done == 1'b0, "R1 we/done", {reg_we, done}, '0);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 handshakes", {in_ready, out_valid}, '0);
        chk(reg_data == '0, "R1 reg_data", reg_data, '0);
    endtask

    task automatic do_load(input int n, input int code, input logic [255:0] mem, input int stall_at, input string tag);
        logic [255:0] expv = model_load(mem, n, width_of(code));
        logic [255:0] msk  = used_mask(n);
        logic [3:0]   wexp = 4'((1 << n) - 1);
        int  b = 0;
        bit  stalled = 0;
        @(negedge clk);
        cfg_count_m1 = 2'(n - 1);
        cfg_size     = 2'(code);
        ld_start     = 1'b1;
        @(negedge clk);
        ld_start = 1'b0;
        chk(in_ready == 1'b1, "R2 ready after start", 256'(in_ready), 256'(1));
        while (b < n) begin
            if (b == stall_at && !stalled) begin
                in_valid = 1'b0;
                stalled  = 1;
                @(negedge clk);
                chk(in_ready == 1'b1 && done == 1'b0, "R6 gap takes no beat", {in_ready, done}, 256'(2));
            end else begin
                in_valid = 1'b1;
                in_data  = mem[b*64 +: 64];
                @(negedge clk);
                b++;
            end
        end
        in_valid = 1'b0;
        chk(done == 1'b1, {"R5 done ", tag}, 256'(done), 256'(1));
        chk(reg_we == wexp, {"R5 reg_we ", tag}, 256'(reg_we), 256'(wexp));
        chk((reg_data & msk) == expv, {"R3 R4 placement ", tag}, reg_data & msk, expv);
        chk(in_ready == 1'b0, {"R2 exactly n beats ", tag}, 256'(in_ready), '0);
        @(negedge clk);
        chk(done == 1'b0 && reg_we == 4'd0, {"R5 single pulse ", tag}, {reg_we, done}, '0);
        chk((reg_data & msk) == expv, {"R5 result held ", tag}, reg_data & msk, expv);
    endtask

    task automatic do_store(input int n, input int code, input logic [255:0] regs, input int stall_at,
                            input string tag, output logic [255:0] got);
        logic [255:0] expm = model_store(regs, n, width_of(code));
        logic [63:0]  held;
        int  b = 0;
        bit  stalled = 0;
        got = '0;
        @(negedge clk);
        cfg_count_m1 = 2'(n - 1);
        cfg_size     = 2'(code);
        st_regs      = regs;
        st_start     = 1'b1;
        @(negedge clk);
        st_start = 1'b0;
        while (b < n) begin
            if (b == stall_at && !stalled) begin
                out_ready = 1'b0;
                stalled   = 1;
                held      = out_data;
                @(negedge clk);
                chk(out_valid == 1'b1 && out_data == held, "R7 beat held while stalled", 256'(out_data), 256'(held));
            end else begin
                out_ready = 1'b1;
                chk(out_valid == 1'b1 && out_data == expm[b*64 +: 64], {"R7 store beat ", tag},
                    256'(out_data), 256'(expm[b*64 +: 64]));
                got[b*64 +: 64] = out_data;
                @(negedge clk);
                b++;
            end
        end
        out_ready = 1'b0;
        chk(done == 1'b1 && reg_we == 4'd0, {"R10 store done ", tag}, {reg_we, done}, 256'(1));
        chk(out_valid == 1'b0, {"R7 exactly n beats ", tag}, 256'(out_valid), '0);
    endtask

    task automatic test_roundtrip();
        logic [255:0] mem = make_mem(91);
        logic [255:0] snap;
        logic [255:0] got;
        do_load(3, 1, mem, -1, "rt");
        snap = reg_data;
        do_store(3, 1, snap, -1, "rt", got);
        chk((got & used_mask(3)) == (mem & used_mask(3)), "R7 round trip", got & used_mask(3), mem & used_mask(3));
    endtask

    task automatic test_busy_ignored();
        logic [255:0] mem = make_mem(55);
        logic [255:0] expv = model_load(mem, 2, 16);
        @(negedge clk);
        cfg_count_m1 = 2'd1;
        cfg_size     = 2'd1;
        ld_start     = 1'b1;
        @(negedge clk);
        ld_start     = 1'b0;
        in_valid     = 1'b1;
        in_data      = mem[63:0];
        st_start     = 1'b1;
        st_regs      = '1;
        cfg_count_m1 = 2'd3;
        cfg_size     = 2'd0;
        @(negedge clk);
        st_start = 1'b0;
        ld_start = 1'b1;
        in_data  = mem[127:64];
        @(negedge clk);
        ld_start = 1'b0;
        in_valid = 1'b0;
        chk(done == 1'b1 && reg_we == 4'b0011, "R8 config kept", {reg_we, done}, {4'b0011, 1'b1});
        chk((reg_data & used_mask(2)) == expv, "R8 data unaffected", reg_data & used_mask(2), expv);
        @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R8 no queued op", {in_ready, out_valid}, '0);
    endtask

    task automatic test_both_starts();
        logic [255:0] mem = make_mem(7);
        @(negedge clk);
        cfg_count_m1 = 2'd0;
        cfg_size     = 2'd2;
        ld_start     = 1'b1;
        st_start     = 1'b1;
        st_regs      = '1;
        @(negedge clk);
        ld_start = 1'b0;
        st_start = 1'b0;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 load wins", {in_ready, out_valid}, 256'(2));
        in_valid = 1'b1;
        in_data  = mem[63:0];
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b1 && reg_data[63:0] == mem[63:0], "R9 load result", 256'(reg_data[63:0]), 256'(mem[63:0]));
    endtask

    initial begin
        logic [255:0] got;
        do_reset();
        do_load(3, 1, make_mem(1), -1, "n3 w16");
        do_load(1, 0, make_mem(2), -1, "n1 w8");
        do_load(2, 2, make_mem(3), -1, "n2 w32");
        do_load(4, 0, make_mem(4), 2, "n4 w8 stall");
        do_load(4, 1, make_mem(5), 0, "n4 w16 stall");
        do_load(2, 3, make_mem(6), -1, "R4 code3");
        do_load(3, 0, make_mem(8), 1, "n3 w8 stall");
        do_store(3, 1, make_mem(10), -1, "n3 w16", got);
        do_store(4, 0, make_mem(11), 1, "n4 w8 stall", got);
        do_store(2, 2, make_mem(12), 0, "n2 w32 stall", got);
        test_roundtrip();
        test_busy_ignored();
        test_both_starts();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule